// File: doc/BRIEF.md
# Truth-Table Driven Integer ALU

A combinational integer ALU of parameterised width (8 bits by default). It takes two operands, a carry/borrow input, a one-bit operation-class select and a 4-bit opcode. It returns a result together with carry-out, overflow and zero flags. When the class select is 0, the block works as a bitwise logic unit. The opcode is then read as a literal truth table: each result bit is the opcode bit addressed by the pair formed from that bit of each operand. This gives all sixteen two-input Boolean functions from one per-bit 4:1 select.

When the class select is 1, the block works as an arithmetic unit. One ripple-carry two's-complement adder serves every arithmetic operation. A conditioning stage in front of it picks the two adder inputs and the carry-in for each opcode. The block is meant to sit between a register read port and a write-back path in a datapath, and it has no state of its own.

Top module: `tt_alu`

## Requirements
- R1: With `op_class`=0, each result bit i equals `opcode[{a[i], b[i]}]`, with `a` as the upper select bit. So code bit 0 is chosen for (a,b)=(0,0), bit 1 for (0,1), bit 2 for (1,0) and bit 3 for (1,1).
- R2: With `op_class`=0, the following codes give the named functions: 4'b1000 AND, 4'b1110 OR, 4'b0110 XOR, 4'b1001 XNOR, 4'b0111 NAND, 4'b0001 NOR, 4'b0000 zero, 4'b1111 all ones, 4'b1100 pass A, 4'b0011 NOT A, 4'b1010 pass B and 4'b0101 NOT B.
- R3: With `op_class`=0, `carry_out` and `overflow` are 0, and `cin` has no effect on any output.
- R4: Arithmetic opcode 0 gives A+B and opcode 1 gives A+B+cin. `carry_out` is the carry out of the top bit.
- R5: Opcode 2 gives A−B, computed as A + ~B + 1. Opcode 3 gives A−B−borrow, computed as A + ~B + ~cin, where cin=1 means a borrow in. `carry_out`=1 means no borrow occurred.
- R6: Opcode 4 gives B−A, computed as B + ~A + 1. Opcode 5 gives B−A−borrow, computed as B + ~A + ~cin.
- R7: Opcode 6 gives −A, computed as 0 + ~A + 1. Opcode 7 gives −B, computed as 0 + ~B + 1.
- R8: Opcode 8 gives A+1 and opcode 9 gives B+1, each computed as operand + 0 with carry-in 1. Opcode 10 gives A−1 and opcode 11 gives B−1, each computed as operand + all-ones with carry-in 0.
- R9: For arithmetic opcodes 0..11, `overflow` is set exactly when the two adder inputs share a sign bit and the result's sign bit differs from it. This equals the XOR of the carries into and out of the top bit.
- R10: For every defined operation, `zero` is 1 exactly when all result bits are 0.
- R11: Arithmetic opcodes 12..15 give a zero result with `carry_out`, `overflow` and `zero` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry in, or borrow in for the borrow forms |
| op_class | input | 1 | 0 selects logic, 1 selects arithmetic |
| opcode | input | 4 | Truth table (logic) or arithmetic operation code |
| result | output | W | Operation result |
| carry_out | output | 1 | Adder carry out; 0 for logic and undefined codes |
| overflow | output | 1 | Signed overflow; 0 for logic and undefined codes |
| zero | output | 1 | Result is all zeros (defined operations only) |

## Verification
Several flags fall together in the same evaluation, and the cases that matter are where they interact. A carry-out and a zero flag coincide when an add wraps exactly to zero (FF+1), and when a subtract has equal operands. Overflow and carry are set together when two large negative numbers are added, and overflow is set with no carry when 7F+1 is computed. These cases are driven as directed vectors. They are then mixed into a few thousand seeded random operand and opcode draws. Every output is compared with a bench model built from the adder-input rules in the requirements, and the named logic codes are compared against plain gate expressions.

// File: rtl/tt_alu_pkg.sv
package tt_alu_pkg;

    typedef enum logic [3:0] {
        AOP_ADD  = 4'd0,
        AOP_ADC  = 4'd1,
        AOP_SUB  = 4'd2,
        AOP_SBB  = 4'd3,
        AOP_RSB  = 4'd4,
        AOP_RSC  = 4'd5,
        AOP_NEGA = 4'd6,
        AOP_NEGB = 4'd7,
        AOP_INCA = 4'd8,
        AOP_INCB = 4'd9,
        AOP_DECA = 4'd10,
        AOP_DECB = 4'd11
    } arith_op_e;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_ZERO = 2'd2,
        SRC_ONES = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        CI_ZERO = 2'd0,
        CI_ONE  = 2'd1,
        CI_CIN  = 2'd2,
        CI_NCIN = 2'd3
    } cin_sel_e;

    typedef struct packed {
        logic     valid;
        src_sel_e x_sel;
        src_sel_e y_sel;
        logic     y_inv;
        cin_sel_e c_sel;
    } cond_ctrl_t;

    typedef struct packed {
        logic carry;
        logic ovf;
        logic zero;
    } alu_flags_t;

    function automatic cond_ctrl_t decode_arith(input logic [3:0] op);
        cond_ctrl_t c;
        c = '{valid: 1'b1, x_sel: SRC_A, y_sel: SRC_B, y_inv: 1'b0, c_sel: CI_ZERO};
        case (op)
            AOP_ADD:  ;
            AOP_ADC:  c.c_sel = CI_CIN;
            AOP_SUB:  begin c.y_inv = 1'b1; c.c_sel = CI_ONE;  end
            AOP_SBB:  begin c.y_inv = 1'b1; c.c_sel = CI_NCIN; end
            AOP_RSB:  begin c.x_sel = SRC_B; c.y_sel = SRC_A; c.y_inv = 1'b1; c.c_sel = CI_ONE;  end
            AOP_RSC:  begin c.x_sel = SRC_B; c.y_sel = SRC_A; c.y_inv = 1'b1; c.c_sel = CI_NCIN; end
            AOP_NEGA: begin c.x_sel = SRC_ZERO; c.y_sel = SRC_A; c.y_inv = 1'b1; c.c_sel = CI_ONE; end
            AOP_NEGB: begin c.x_sel = SRC_ZERO; c.y_sel = SRC_B; c.y_inv = 1'b1; c.c_sel = CI_ONE; end
            AOP_INCA: begin c.y_sel = SRC_ZERO; c.c_sel = CI_ONE; end
            AOP_INCB: begin c.x_sel = SRC_B; c.y_sel = SRC_ZERO; c.c_sel = CI_ONE; end
            AOP_DECA: begin c.y_sel = SRC_ONES; end
            AOP_DECB: begin c.x_sel = SRC_B; c.y_sel = SRC_ONES; end
            default:  c.valid = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tt_alu_logic_unit.sv
module tt_alu_logic_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   table_code,
    output logic [W-1:0] y
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] sel;
        assign sel  = {a[i], b[i]};
        assign y[i] = table_code[sel];
    end

    // R1
    always_comb begin
        tt_all_ones_chk: assert (table_code != 4'hF || y == {W{1'b1}});
    end
endmodule

// File: rtl/tt_alu_operand_cond.sv
module tt_alu_operand_cond
    import tt_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  cond_ctrl_t   ctrl,
    output logic [W-1:0] x,
    output logic [W-1:0] y,
    output logic         c0
);
    function automatic logic [W-1:0] pick(input src_sel_e s,
                                          input logic [W-1:0] va,
                                          input logic [W-1:0] vb);
        case (s)
            SRC_A:    return va;
            SRC_B:    return vb;
            SRC_ZERO: return '0;
            default:  return '1;
        endcase
    endfunction

    logic [W-1:0] y_raw;

    always_comb begin
        x     = pick(ctrl.x_sel, a, b);
        y_raw = pick(ctrl.y_sel, a, b);
        y     = ctrl.y_inv ? ~y_raw : y_raw;
        case (ctrl.c_sel)
            CI_ZERO: c0 = 1'b0;
            CI_ONE:  c0 = 1'b1;
            CI_CIN:  c0 = cin;
            default: c0 = ~cin;
        endcase
    end
endmodule

// File: rtl/tt_alu_ripple_adder.sv
module tt_alu_ripple_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c0,
    output logic [W-1:0] sum,
    output logic         c_top,
    output logic         c_into_top
);
    logic [W:0] c;
    assign c[0] = c0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign sum[i]  = x[i] ^ y[i] ^ c[i];
        assign c[i+1]  = (x[i] & y[i]) | (x[i] & c[i]) | (y[i] & c[i]);
    end

    assign c_top      = c[W];
    assign c_into_top = c[W-1];
endmodule

// File: rtl/tt_alu.sv
module tt_alu
    import tt_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         op_class,
    input  logic [3:0]   opcode,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         overflow,
    output logic         zero
);
    localparam logic [W-1:0] ALL_ZERO = '0;

    logic [W-1:0] logic_y;
    logic [W-1:0] add_x, add_y, add_sum;
    logic         add_c0, add_ctop, add_cin_top;
    cond_ctrl_t   ctrl;
    alu_flags_t   flags;

    assign ctrl = decode_arith(opcode);

    tt_alu_logic_unit #(.W(W)) u_logic (
        .a(a), .b(b), .table_code(opcode), .y(logic_y)
    );

    tt_alu_operand_cond #(.W(W)) u_cond (
        .a(a), .b(b), .cin(cin), .ctrl(ctrl),
        .x(add_x), .y(add_y), .c0(add_c0)
    );

    tt_alu_ripple_adder #(.W(W)) u_add (
        .x(add_x), .y(add_y), .c0(add_c0),
        .sum(add_sum), .c_top(add_ctop), .c_into_top(add_cin_top)
    );

    always_comb begin
        if (!op_class) begin
            result      = logic_y;
            flags.carry = 1'b0;
            flags.ovf   = 1'b0;
            flags.zero  = (logic_y == ALL_ZERO);
        end else if (ctrl.valid) begin
            result      = add_sum;
            flags.carry = add_ctop;
            flags.ovf   = add_ctop ^ add_cin_top;
            flags.zero  = (add_sum == ALL_ZERO);
        end else begin
            result      = ALL_ZERO;
            flags       = '0;
        end
    end

    assign carry_out = flags.carry;
    assign overflow  = flags.ovf;
    assign zero      = flags.zero;

    always_comb begin
        // R3
        logic_flags_chk: assert (op_class || (!carry_out && !overflow));
        // R11
        undef_quiet_chk: assert (!(op_class && opcode > 4'd11) ||
                                 (result == ALL_ZERO && !carry_out && !overflow && !zero));
        // R4
        add_sum_chk: assert (!(op_class && opcode == 4'd0) || result == W'(a + b));
        // R10
        zero_result_chk: assert (!zero || result == ALL_ZERO);
        // R9
        ovf_sign_chk: assert (!(op_class && opcode == 4'd0 && a[W-1] != b[W-1]) || !overflow);
    end
endmodule

// File: tb/tb_tt_alu.sv
module tb_tt_alu;
    localparam int W = 8;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic [W-1:0] a, b, result;
    logic         cin, op_class, carry_out, overflow, zero;
    logic [3:0]   opcode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tt_alu #(.W(W)) dut (
        .a(a), .b(b), .cin(cin), .op_class(op_class), .opcode(opcode),
        .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s cls=%0d op=%0d a=%h b=%h cin=%0d act=%h exp=%h",
                     tag, what, op_class, opcode, a, b, cin, act, exp);
        end
    endtask

    function automatic string tag_of(input logic cls, input logic [3:0] op);
        if (!cls) return "R1";
        case (op)
            4'd0, 4'd1:               return "R4";
            4'd2, 4'd3:               return "R5";
            4'd4, 4'd5:               return "R6";
            4'd6, 4'd7:               return "R7";
            4'd8, 4'd9, 4'd10, 4'd11: return "R8";
            default:                  return "R11";
        endcase
    endfunction

    task automatic model(input logic cls, input logic [3:0] op,
                         input logic [W-1:0] va, input logic [W-1:0] vb, input logic ci,
                         output logic [W-1:0] r, output logic c, output logic v, output logic z);
        logic [W-1:0] x, y;
        logic         c0;
        logic [W:0]   s;
        r = '0; c = 0; v = 0; z = 0;
        if (!cls) begin
            for (int i = 0; i < W; i++) r[i] = op[{va[i], vb[i]}];
            z = (r == 0);
            return;
        end
        case (op)
            4'd0:  begin x = va; y = vb;  c0 = 0;   end
            4'd1:  begin x = va; y = vb;  c0 = ci;  end
            4'd2:  begin x = va; y = ~vb; c0 = 1;   end
            4'd3:  begin x = va; y = ~vb; c0 = ~ci; end
            4'd4:  begin x = vb; y = ~va; c0 = 1;   end
            4'd5:  begin x = vb; y = ~va; c0 = ~ci; end
            4'd6:  begin x = 0;  y = ~va; c0 = 1;   end
            4'd7:  begin x = 0;  y = ~vb; c0 = 1;   end
            4'd8:  begin x = va; y = 0;   c0 = 1;   end
            4'd9:  begin x = vb; y = 0;   c0 = 1;   end
            4'd10: begin x = va; y = '1;  c0 = 0;   end
            4'd11: begin x = vb; y = '1;  c0 = 0;   end
            default: return;
        endcase
        s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
        r = s[W-1:0];
        c = s[W];
        v = (x[W-1] == y[W-1]) && (r[W-1] != x[W-1]);
        z = (r == 0);
    endtask

    task automatic apply(input logic cls, input logic [3:0] op,
                         input logic [W-1:0] va, input logic [W-1:0] vb, input logic ci);
        logic [W-1:0] er;
        logic ec, ev, ez;
        string t;
        @(negedge clk);
        op_class = cls; opcode = op; a = va; b = vb; cin = ci;
        @(posedge clk); #1;
        model(cls, op, va, vb, ci, er, ec, ev, ez);
        t = tag_of(cls, op);
        chk(t, "result", 32'(result), 32'(er));
        chk(cls ? t : "R3", "carry", 32'(carry_out), 32'(ec));
        chk(cls ? "R9" : "R3", "overflow", 32'(overflow), 32'(ev));
        chk("R10", "zero", 32'(zero), 32'(ez));
    endtask

    task automatic directed_exact(input string tag, input logic cls, input logic [3:0] op,
                                  input logic [W-1:0] va, input logic [W-1:0] vb, input logic ci,
                                  input logic [W-1:0] er, input logic ec, input logic ev,
                                  input logic ez);
        @(negedge clk);
        op_class = cls; opcode = op; a = va; b = vb; cin = ci;
        @(posedge clk); #1;
        chk(tag, "result", 32'(result), 32'(er));
        chk(tag, "carry", 32'(carry_out), 32'(ec));
        chk(tag, "overflow", 32'(overflow), 32'(ev));
        chk(tag, "zero", 32'(zero), 32'(ez));
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] pa, pb;
        a = '0; b = '0; cin = 0; op_class = 0; opcode = '0;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        // reset-like idle state: logic code 0 on zero operands
        directed_exact("R1", 0, 4'h0, 8'h00, 8'h00, 0, 8'h00, 0, 0, 1);

        // R2 named codes against plain gate expressions
        pa = 8'hCC; pb = 8'hAA;
        directed_exact("R2", 0, 4'b1000, pa, pb, 0, pa & pb, 0, 0, 0);
        directed_exact("R2", 0, 4'b1110, pa, pb, 0, pa | pb, 0, 0, 0);
        directed_exact("R2", 0, 4'b0110, pa, pb, 0, pa ^ pb, 0, 0, 0);
        directed_exact("R2", 0, 4'b1001, pa, pb, 0, ~(pa ^ pb), 0, 0, 0);
        directed_exact("R2", 0, 4'b0111, pa, pb, 0, ~(pa & pb), 0, 0, 0);
        directed_exact("R2", 0, 4'b0001, pa, pb, 0, ~(pa | pb), 0, 0, 0);
        directed_exact("R2", 0, 4'b0000, pa, pb, 0, 8'h00, 0, 0, 1);
        directed_exact("R2", 0, 4'b1111, pa, pb, 0, 8'hFF, 0, 0, 0);
        directed_exact("R2", 0, 4'b1100, pa, pb, 0, pa, 0, 0, 0);
        directed_exact("R2", 0, 4'b0011, pa, pb, 0, ~pa, 0, 0, 0);
        directed_exact("R2", 0, 4'b1010, pa, pb, 0, pb, 0, 0, 0);
        directed_exact("R2", 0, 4'b0101, pa, pb, 0, ~pb, 0, 0, 0);
        // R3 cin ignored in logic class
        directed_exact("R3", 0, 4'b1110, 8'hFF, 8'hFF, 1, 8'hFF, 0, 0, 0);

        // R4 / R9 / R10 corner cases
        directed_exact("R9", 1, 4'd0, 8'h7F, 8'h01, 0, 8'h80, 0, 1, 0);
        directed_exact("R10", 1, 4'd0, 8'hFF, 8'h01, 0, 8'h00, 1, 0, 1);
        directed_exact("R9", 1, 4'd0, 8'h80, 8'h80, 0, 8'h00, 1, 1, 1);
        directed_exact("R4", 1, 4'd1, 8'h10, 8'h20, 1, 8'h31, 0, 0, 0);
        // R5 borrow conventions
        directed_exact("R5", 1, 4'd2, 8'h05, 8'h05, 0, 8'h00, 1, 0, 1);
        directed_exact("R5", 1, 4'd2, 8'h00, 8'h01, 0, 8'hFF, 0, 0, 0);
        directed_exact("R5", 1, 4'd3, 8'h05, 8'h03, 1, 8'h01, 1, 0, 0);
        directed_exact("R5", 1, 4'd3, 8'h05, 8'h03, 0, 8'h02, 1, 0, 0);
        // R6 reverse subtract
        directed_exact("R6", 1, 4'd4, 8'h03, 8'h0A, 0, 8'h07, 1, 0, 0);
        directed_exact("R6", 1, 4'd5, 8'h03, 8'h0A, 1, 8'h06, 1, 0, 0);
        // R7 negation
        directed_exact("R7", 1, 4'd6, 8'h80, 8'h00, 0, 8'h80, 0, 1, 0);
        directed_exact("R7", 1, 4'd6, 8'h00, 8'h55, 0, 8'h00, 1, 0, 1);
        directed_exact("R7", 1, 4'd7, 8'h00, 8'h01, 0, 8'hFF, 0, 0, 0);
        // R8 increment / decrement
        directed_exact("R8", 1, 4'd8, 8'hFF, 8'h00, 0, 8'h00, 1, 0, 1);
        directed_exact("R8", 1, 4'd9, 8'h00, 8'h7F, 0, 8'h80, 0, 1, 0);
        directed_exact("R8", 1, 4'd10, 8'h00, 8'h00, 0, 8'hFF, 0, 0, 0);
        directed_exact("R8", 1, 4'd11, 8'h00, 8'h80, 0, 8'h7F, 1, 1, 0);
        // R11 undefined opcodes
        for (int op = 12; op < 16; op++)
            directed_exact("R11", 1, 4'(op), 8'h00, 8'h00, 1, 8'h00, 0, 0, 0);

        // random mix over all classes and opcodes
        for (int n = 0; n < 3000; n++)
            apply(1'($urandom), 4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

        done = 1'b1;
        finish_run();
    end
endmodule